// File: doc/BRIEF.md
# APB Write-FIFO Slave with Sticky Error Causes

This block is an APB completer that accepts data words into a write FIFO and hands them to an internal consumer over a valid/ready drain port. Software writes words into a data register, reads the FIFO occupancy from a level register, and reads a status register whose bits record why earlier accesses were refused.

Any access the slave cannot honour still completes on the bus, but with PSLVERR high. Three conditions cause this: an unmapped offset, a protection attribute that is too weak, or a data write that meets a full FIFO. Each refusal sets a dedicated sticky cause bit, which software clears by writing ones. An error reported on the bus is therefore always matched by a readable reason.

Data writes can be stretched by a parameterised number of wait cycles. The verdict and PREADY are both registered, so they are steady for the whole completion cycle.

Top module: `apb_sticky_fifo`

## Requirements
- R1: `pslverr` is high only in a cycle where `pready` is high. Both outputs are low in the setup cycle and in every wait cycle.
- R2: A write to the data offset (0x0) completes WR_WAIT+1 access cycles after its setup cycle. Every other access completes in its first access cycle. `pready` is high for exactly one cycle per transfer.
- R3: A data write that finds the FIFO full, with no pop in the same cycle, is not stored. It completes with `pslverr`=1 and sets status bit 0 (overflow).
- R4: A data write to a full FIFO in the same cycle as a drain pop is accepted without error. The occupancy does not change.
- R5: An access to an offset other than 0x0, 0x4 or 0x8 completes with `pslverr`=1, sets status bit 2 (bad offset) and has no other effect.
- R6: Every access except a status read needs `pprot[0]`=1 (privileged) and `pprot[1]`=0 (secure). A failing access completes with `pslverr`=1, sets status bit 1 (protection) and has no other effect, which includes a status write clearing nothing.
- R7: A refused access sets exactly one cause bit. A bad offset is chosen over a protection failure, and a protection failure over an overflow.
- R8: A read of the status offset (0x4) never errors, whatever its `pprot`. It returns the cause bits in `prdata[2:0]` and zero above them.
- R9: Writing a 1 to a status bit clears it, and writing a 0 leaves it unchanged. A bit that is set stays set until it is cleared. A cause raised in the same cycle as a clear wins over the clear.
- R10: A read of the level offset (0x8) returns the FIFO occupancy. A write to the level offset is ignored and does not error. A read of the data offset returns 0 and does not error. Writes return `prdata`=0.
- R11: `drain_valid` is high exactly when the FIFO holds data. `drain_data` shows the oldest word. A word is removed when `drain_valid` and `drain_ready` are both high, and words leave in the order they were written.
- R12: After reset the FIFO is empty, all status bits are 0, and `pready`, `pslverr` and `prdata` are 0.
- R13: Whenever `pslverr` is high, at least one status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase indicator |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte offset of the register |
| pwdata | input | DATA_W | Write data |
| pprot | input | 3 | Protection attributes ([0] privileged, [1] non-secure, [2] instruction) |
| prdata | output | DATA_W | Read data, valid in the completion cycle |
| pready | output | 1 | Completion of the transfer |
| pslverr | output | 1 | Transfer refused, valid with pready |
| drain_valid | output | 1 | FIFO holds a word |
| drain_data | output | DATA_W | Oldest FIFO word |
| drain_ready | input | 1 | Consumer takes the word this cycle |

## Verification
The assertions assume a protocol-abiding requester. Every transfer starts with one setup cycle with `penable` low. `psel`, `paddr`, `pwrite`, `pwdata` and `pprot` then hold steady until the cycle in which `pready` is seen, and `penable` never rises without a preceding setup cycle. The bench drives every transfer from a single task that follows this sequence and returns to idle after completion. Only `drain_ready` toggles freely, including in the exact cycle in which a write to a full FIFO is decided.

// File: rtl/sfq_pkg.sv
package sfq_pkg;

    // register offsets decoded by the slave
    localparam int OFS_DATA = 'h0;
    localparam int OFS_STAT = 'h4;
    localparam int OFS_LVL  = 'h8;

    // sticky cause bit positions
    localparam int ST_OVF  = 0;
    localparam int ST_PROT = 1;
    localparam int ST_DEC  = 2;
    localparam int ST_W    = 3;

    typedef enum logic [1:0] {
        REG_DATA,
        REG_STAT,
        REG_LVL,
        REG_NONE
    } reg_sel_e;

    typedef enum logic [1:0] {
        VERD_OK,
        VERD_DECODE,
        VERD_PROT,
        VERD_OVF
    } verdict_e;

    // privileged and secure are both required; instruction/data is don't-care
    function automatic logic prot_sufficient(input logic [2:0] prot);
        logic ok;
        ok = prot[0] && !prot[1];
        if (prot[2] === 1'bx) ok = 1'b0;
        return ok;
    endfunction

    function automatic logic [ST_W-1:0] cause_mask(input verdict_e v);
        logic [ST_W-1:0] m;
        m = '0;
        case (v)
            VERD_OVF:    m[ST_OVF]  = 1'b1;
            VERD_PROT:   m[ST_PROT] = 1'b1;
            VERD_DECODE: m[ST_DEC]  = 1'b1;
            default:     m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/sfq_fifo.sv
module sfq_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             push,
    input  logic [DATA_W-1:0]                push_data,
    input  logic                             pop_ready,
    output logic                             pop_valid,
    output logic [DATA_W-1:0]                pop_data,
    output logic                             full,
    output logic [$clog2(DEPTH+1)-1:0]       count
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  count_q;
    logic              pop;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign pop       = pop_valid && pop_ready;
    assign pop_valid = (count_q != '0);
    assign full      = (count_q == CNT_W'(DEPTH));
    assign pop_data  = mem[rd_ptr];
    assign count     = count_q;

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count_q <= '0;
        end else begin
            if (push) wr_ptr <= ptr_next(wr_ptr);
            if (pop)  rd_ptr <= ptr_next(rd_ptr);
            case ({push, pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        push |-> (!full || pop));                                   // R3
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        count_q <= CNT_W'(DEPTH));                                  // R11

endmodule

// File: rtl/sfq_decode.sv
module sfq_decode
    import sfq_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] paddr,
    input  logic              pwrite,
    input  logic [2:0]        pprot,
    input  logic              fifo_full,
    input  logic              pop_now,
    output reg_sel_e          sel,
    output verdict_e          verdict
);
    always_comb begin
        if (paddr == ADDR_W'(OFS_DATA))      sel = REG_DATA;
        else if (paddr == ADDR_W'(OFS_STAT)) sel = REG_STAT;
        else if (paddr == ADDR_W'(OFS_LVL))  sel = REG_LVL;
        else                                 sel = REG_NONE;
    end

    // first failed test decides: offset, then protection, then capacity
    always_comb begin
        if (sel == REG_NONE)
            verdict = VERD_DECODE;
        else if (sel == REG_STAT && !pwrite)
            verdict = VERD_OK;
        else if (!prot_sufficient(pprot))
            verdict = VERD_PROT;
        else if (sel == REG_DATA && pwrite && fifo_full && !pop_now)
            verdict = VERD_OVF;
        else
            verdict = VERD_OK;
    end

endmodule

// File: rtl/sfq_access_ctrl.sv
module sfq_access_ctrl #(
    parameter int WR_WAIT = 0
) (
    input  logic clk,
    input  logic rst,
    input  logic psel,
    input  logic penable,
    input  logic need_wait,
    input  logic err_in,
    output logic commit,
    output logic pready,
    output logic pslverr
);
    localparam int WAIT_W   = $clog2(WR_WAIT + 2);
    localparam bit HAS_WAIT = (WR_WAIT > 0);

    logic              setup, access;
    logic              rdy_q, err_q;
    logic [WAIT_W-1:0] wait_q;

    assign setup  = psel && !penable;
    assign access = psel && penable;

    // the verdict is taken one cycle ahead of completion so it can be registered
    assign commit = (setup && !(need_wait && HAS_WAIT)) ||
                    (access && !rdy_q && (wait_q <= WAIT_W'(1)));

    always_ff @(posedge clk) begin
        if (rst) begin
            rdy_q  <= 1'b0;
            err_q  <= 1'b0;
            wait_q <= '0;
        end else if (commit) begin
            rdy_q  <= 1'b1;
            err_q  <= err_in;
            wait_q <= '0;
        end else if (setup && need_wait) begin
            rdy_q  <= 1'b0;
            err_q  <= 1'b0;
            wait_q <= WAIT_W'(WR_WAIT);
        end else if (access && !rdy_q) begin
            wait_q <= wait_q - 1'b1;
        end else begin
            rdy_q  <= 1'b0;
            err_q  <= 1'b0;
        end
    end

    assign pready  = rdy_q;
    assign pslverr = err_q;

    AST_ERR_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        pslverr |-> pready);                                        // R1
    AST_SETUP_QUIET: assert property (@(posedge clk) disable iff (rst)
        (psel && !penable) |-> (!pready && !pslverr));              // R1
    AST_ONE_DONE: assert property (@(posedge clk) disable iff (rst)
        pready |=> !pready);                                        // R2

endmodule

// File: rtl/sfq_status.sv
module sfq_status
    import sfq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [ST_W-1:0] set,
    input  logic [ST_W-1:0] clr,
    output logic [ST_W-1:0] q
);
    // a cause raised this cycle overrides a clear of the same bit
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= (q & ~clr) | set;
    end

    for (genvar b = 0; b < ST_W; b++) begin : g_bit
        AST_STICKY_SET: assert property (@(posedge clk) disable iff (rst)
            set[b] |=> q[b]);                                       // R9
        AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
            (q[b] && !clr[b]) |=> q[b]);                            // R9
    end

endmodule

// File: rtl/apb_sticky_fifo.sv
module apb_sticky_fifo
    import sfq_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32,
    parameter int DEPTH   = 8,
    parameter int WR_WAIT = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    input  logic [2:0]        pprot,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    output logic              drain_valid,
    output logic [DATA_W-1:0] drain_data,
    input  logic              drain_ready
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    reg_sel_e          sel;
    verdict_e          verdict;
    logic              commit, need_wait, fifo_full, pop_now, push, accept;
    logic [CNT_W-1:0]  level;
    logic [ST_W-1:0]   st_set, st_clr, st_q;
    logic [DATA_W-1:0] rdata_q;

    assign pop_now   = drain_valid && drain_ready;
    assign need_wait = pwrite && (sel == REG_DATA);
    assign accept    = commit && (verdict == VERD_OK);

    sfq_decode #(.ADDR_W(ADDR_W)) i_decode (
        .paddr     (paddr),
        .pwrite    (pwrite),
        .pprot     (pprot),
        .fifo_full (fifo_full),
        .pop_now   (pop_now),
        .sel       (sel),
        .verdict   (verdict)
    );

    sfq_access_ctrl #(.WR_WAIT(WR_WAIT)) i_ctrl (
        .clk       (clk),
        .rst       (rst),
        .psel      (psel),
        .penable   (penable),
        .need_wait (need_wait),
        .err_in    (verdict != VERD_OK),
        .commit    (commit),
        .pready    (pready),
        .pslverr   (pslverr)
    );

    assign push = accept && pwrite && (sel == REG_DATA);

    sfq_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_data (pwdata),
        .pop_ready (drain_ready),
        .pop_valid (drain_valid),
        .pop_data  (drain_data),
        .full      (fifo_full),
        .count     (level)
    );

    assign st_set = commit ? cause_mask(verdict) : '0;
    assign st_clr = (accept && pwrite && sel == REG_STAT) ? pwdata[ST_W-1:0] : '0;

    sfq_status i_status (
        .clk (clk),
        .rst (rst),
        .set (st_set),
        .clr (st_clr),
        .q   (st_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (commit) begin
            if (accept && !pwrite) begin
                case (sel)
                    REG_STAT: rdata_q <= DATA_W'(st_q);
                    REG_LVL:  rdata_q <= DATA_W'(level);
                    default:  rdata_q <= '0;
                endcase
            end else begin
                rdata_q <= '0;
            end
        end
    end

    assign prdata = rdata_q;

    AST_ERR_BACKED: assert property (@(posedge clk) disable iff (rst)
        pslverr |-> (st_q != '0));                                  // R13

endmodule

// File: tb/test_apb_sticky_fifo.sv
`timescale 1ns/100ps
module test_apb_sticky_fifo;
    localparam int TB_DEPTH = 4;
    localparam int TB_WAIT  = 2;
    localparam logic [2:0] PRIV = 3'b001;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [2:0]  pprot = '0;
    logic [31:0] prdata;
    logic        pready, pslverr, drain_valid;
    logic [31:0] drain_data;
    logic        drain_ready = 1'b0;

    int checks = 0;
    int errors = 0;
    bit ended  = 1'b0;

    logic [31:0] ref_q[$];
    logic [2:0]  ref_st = '0;
    bit          push_pending = 1'b0;
    logic [31:0] push_val = '0;

    always #2.5 clk = ~clk;

    apb_sticky_fifo #(.ADDR_W(12), .DATA_W(32), .DEPTH(TB_DEPTH), .WR_WAIT(TB_WAIT))
    i_apb_sticky_fifo (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .pprot(pprot), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .drain_valid(drain_valid),
        .drain_data(drain_data), .drain_ready(drain_ready)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // reference model of the drain side, compared on every clock (R11)
    always @(negedge clk) begin
        if (!rst) begin
            chk("R11", "drain_valid", 32'(drain_valid), 32'(ref_q.size() != 0));
            if (ref_q.size() != 0) chk("R11", "drain_data", drain_data, ref_q[0]);
            if (drain_ready && ref_q.size() != 0) void'(ref_q.pop_front());
            if (push_pending) begin
                ref_q.push_back(push_val);
                push_pending = 1'b0;
            end
        end
    end

    // model decision for the cycle before completion
    task automatic model_commit(input bit wr, input logic [11:0] addr,
                                input logic [31:0] wd, input logic [2:0] prot,
                                input bit popping, output bit e_err,
                                output logic [31:0] e_rd);
        bit mapped, prot_ok;
        logic [2:0] cause;
        mapped  = (addr == 12'h0) || (addr == 12'h4) || (addr == 12'h8);
        prot_ok = prot[0] && !prot[1];
        cause   = 3'b000;
        if (!mapped)                                  cause = 3'b100;
        else if (addr == 12'h4 && !wr)                cause = 3'b000;
        else if (!prot_ok)                            cause = 3'b010;
        else if (addr == 12'h0 && wr && ref_q.size() == TB_DEPTH && !popping)
                                                      cause = 3'b001;
        e_err = (cause != 3'b000);
        e_rd  = 32'h0;
        if (!e_err && !wr) begin
            if (addr == 12'h4)      e_rd = 32'(ref_st);
            else if (addr == 12'h8) e_rd = 32'(ref_q.size());
        end
        ref_st = ref_st | cause;
        if (!e_err && wr && addr == 12'h4) ref_st = ref_st & ~wd[2:0];
        if (!e_err && wr && addr == 12'h0) begin
            push_pending = 1'b1;
            push_val     = wd;
        end
    endtask

    task automatic xfer(input string tag, input bit wr, input logic [11:0] addr,
                        input logic [31:0] wd, input logic [2:0] prot,
                        input bit pop_commit);
        int          waits;
        bit          e_err;
        logic [31:0] e_rd;
        waits = (wr && addr == 12'h0) ? TB_WAIT : 0;
        @(posedge clk); #1;
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = addr; pwdata = wd; pprot = prot;
        if (waits == 0) begin
            if (pop_commit) drain_ready = 1'b1;
            model_commit(wr, addr, wd, prot, pop_commit && ref_q.size() != 0, e_err, e_rd);
        end
        @(negedge clk);
        chk("R1", {tag, " setup pready"}, 32'(pready), 32'h0);
        chk("R1", {tag, " setup pslverr"}, 32'(pslverr), 32'h0);
        for (int k = 1; k <= waits; k++) begin
            @(posedge clk); #1;
            penable = 1'b1;
            if (k == waits) begin
                if (pop_commit) drain_ready = 1'b1;
                model_commit(wr, addr, wd, prot, pop_commit && ref_q.size() != 0, e_err, e_rd);
            end
            @(negedge clk);
            chk("R2", {tag, " wait pready"}, 32'(pready), 32'h0);
            chk("R1", {tag, " wait pslverr"}, 32'(pslverr), 32'h0);
        end
        @(posedge clk); #1;
        penable = 1'b1;
        if (pop_commit) drain_ready = 1'b0;
        @(negedge clk);
        chk("R2", {tag, " done pready"}, 32'(pready), 32'h1);
        chk(tag, "pslverr", 32'(pslverr), 32'(e_err));
        chk(tag, "prdata", prdata, e_rd);
        @(posedge clk); #1;
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic drain(input int n);
        @(posedge clk); #1;
        drain_ready = 1'b1;
        repeat (n) @(posedge clk);
        #1 drain_ready = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R12", "reset pready", 32'(pready), 32'h0);
        chk("R12", "reset pslverr", 32'(pslverr), 32'h0);
        chk("R12", "reset drain_valid", 32'(drain_valid), 32'h0);
        chk("R12", "reset prdata", prdata, 32'h0);
        @(posedge clk); #1 rst = 1'b0;

        xfer("R12", 0, 12'h4, 0, PRIV, 0);          // status after reset = 0
        xfer("R10", 0, 12'h8, 0, PRIV, 0);          // empty level
        xfer("R2",  1, 12'h0, 32'h11, PRIV, 0);
        xfer("R2",  1, 12'h0, 32'h22, PRIV, 0);
        xfer("R2",  1, 12'h0, 32'h33, PRIV, 0);
        xfer("R10", 0, 12'h8, 0, PRIV, 0);          // level 3
        xfer("R10", 0, 12'h0, 0, PRIV, 0);          // data read returns 0
        xfer("R10", 1, 12'h8, 32'h5, PRIV, 0);      // level write ignored
        xfer("R10", 0, 12'h8, 0, PRIV, 0);
        drain(5);
        xfer("R11", 0, 12'h8, 0, PRIV, 0);

        for (int i = 0; i < TB_DEPTH; i++) xfer("R11", 1, 12'h0, 32'hA0 + i, PRIV, 0);
        xfer("R3",  1, 12'h0, 32'hBAD, PRIV, 0);    // overflow
        xfer("R3",  0, 12'h8, 0, PRIV, 0);
        xfer("R13", 0, 12'h4, 0, PRIV, 0);          // bit0 set
        xfer("R4",  1, 12'h0, 32'hC4, PRIV, 1);     // push with pop when full
        xfer("R4",  0, 12'h8, 0, PRIV, 0);
        xfer("R4",  0, 12'h4, 0, PRIV, 0);
        drain(6);

        xfer("R5",  1, 12'h10, 32'h1, PRIV, 0);     // unmapped write
        xfer("R5",  0, 12'h0C, 0, PRIV, 0);         // unmapped read
        xfer("R5",  0, 12'h4, 0, PRIV, 0);
        xfer("R6",  1, 12'h0, 32'h77, 3'b000, 0);   // unprivileged
        xfer("R6",  1, 12'h0, 32'h78, 3'b011, 0);   // non-secure
        xfer("R6",  0, 12'h8, 0, PRIV, 0);          // nothing stored
        xfer("R8",  0, 12'h4, 0, 3'b010, 0);        // status read never errors
        xfer("R6",  0, 12'h8, 0, 3'b000, 0);        // level read needs privilege

        xfer("R9",  1, 12'h4, 32'h7, PRIV, 0);      // clear all
        xfer("R9",  0, 12'h4, 0, PRIV, 0);
        xfer("R7",  1, 12'h20, 32'h0, 3'b000, 0);   // offset beats protection
        xfer("R7",  0, 12'h4, 0, PRIV, 0);
        xfer("R9",  1, 12'h4, 32'h4, PRIV, 0);
        for (int i = 0; i < TB_DEPTH; i++) xfer("R7", 1, 12'h0, 32'hB0 + i, PRIV, 0);
        xfer("R7",  1, 12'h0, 32'hEE, 3'b000, 0);   // protection beats overflow
        xfer("R7",  0, 12'h4, 0, PRIV, 0);
        xfer("R3",  1, 12'h0, 32'hEF, PRIV, 0);     // overflow -> status 3
        xfer("R9",  1, 12'h4, 32'h1, PRIV, 0);      // clear bit0 only
        xfer("R9",  0, 12'h4, 0, PRIV, 0);
        xfer("R6",  1, 12'h4, 32'h2, 3'b000, 0);    // rejected clear
        xfer("R9",  0, 12'h4, 0, PRIV, 0);
        xfer("R9",  1, 12'h4, 32'h2, PRIV, 0);
        xfer("R9",  0, 12'h4, 0, PRIV, 0);
        drain(6);
        xfer("R11", 0, 12'h8, 0, PRIV, 0);

        repeat (3) @(posedge clk);
        finish_run();
    end

endmodule